// File: doc/BRIEF.md
# Framer Status and Control Register Bank

This block is the register bank that sits between a host bus and a packet-over-SONET framer. It has a plain bus port: an address, a read strobe, a write strobe, write data, and read data that is registered. Two groups of addresses return fixed status patterns. One 16-bit control register can be read and written, and the value written to it selects the length of the frame check sequence that the framer appends. The block passes that choice on as a single bit.

The block also keeps an interrupt line to the host. A pulse on the set input raises the line. No write clears it. The line drops only after a set number of reads spread across the primary status addresses. A shared counter counts those reads. The counter starts again from zero each time it reaches its limit, and a new set event never restarts it.

Top module: `pos_csr_bank`

## Requirements
- R1: After reset, read data is zero, the interrupt is low, the CRC select is 0 (2 bytes), the bad-value flag is low, and the control register reads as zero.
- R2: A read of any primary status address (0x300000, 0x300004, 0x30001C) returns 0x00000FFF on the read data in the cycle after the read strobe.
- R3: A read of the auxiliary status address 0x300008 returns 0x0000007F in the cycle after the read strobe.
- R4: The control register at 0x300028 stores write-data bits 15:0. A read returns that value zero-extended to 32 bits.
- R5: In the cycle after a control write, the CRC select shows 1 (4-byte CRC) if the whole 32-bit written word equals 0x00000007. It shows 0 (2-byte CRC) if the word equals 0x00000006.
- R6: Any other written word is still stored as in R4. It sets the CRC select to 0 and pulses the bad-value flag high for exactly one cycle. A word such as 0x00010007 counts as another word.
- R7: A high cycle on the interrupt-set input makes the interrupt output high in the next cycle.
- R8: Each read of a primary status address advances a shared counter. In the cycle after the 20th such read, the interrupt output goes low and the counter returns to zero. Reads of other addresses do not advance the counter.
- R9: A set pulse while the interrupt is already high leaves the counter's progress unchanged.
- R10: A read of an undecoded address returns zero. A write to an undecoded address changes neither the control register nor the CRC select.
- R11: In every cycle that follows a cycle with no read strobe, the read data is zero.
- R12: If a set pulse arrives in the same cycle as the clearing 20th read, the interrupt stays high and the counter still returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_set | input | 1 | Interrupt set event |
| irq_out | output | 1 | Pending interrupt |
| crc_long | output | 1 | CRC select: 0 for 2 bytes, 1 for 4 bytes |
| ctrl_bad | output | 1 | One-cycle flag for an unrecognised control word |

## Verification
Some rules are checked by assertions on every cycle. These are the fixed read values and the zero idle read data, the interrupt rising after a set, the interrupt falling only right after a primary status read, and the CRC select following a control write. Other behaviour depends on a history of many reads, so only the bench scenarios can show it. That covers clearing on exactly the 20th read, a set pulse that leaves the count unchanged, a set that arrives with the clearing read, and writes to undecoded addresses leaving the control register unchanged. A reference model in the bench checks all of these.

// File: rtl/pos_csr_pkg.sv
package pos_csr_pkg;

    localparam int unsigned OFF_STAT_A = 32'h0030_0000;
    localparam int unsigned OFF_STAT_B = 32'h0030_0004;
    localparam int unsigned OFF_STAT_C = 32'h0030_001C;
    localparam int unsigned OFF_STAT_X = 32'h0030_0008;
    localparam int unsigned OFF_CTRL   = 32'h0030_0028;

    localparam int unsigned CTRL_WORD_SHORT = 32'h0000_0006;
    localparam int unsigned CTRL_WORD_LONG  = 32'h0000_0007;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_GRP  = 2'd1,
        SEL_AUX  = 2'd2,
        SEL_CTRL = 2'd3
    } csr_sel_e;

endpackage

// File: rtl/pos_csr_decode.sv
module pos_csr_decode
    import pos_csr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output csr_sel_e          sel,
    output logic              grp_rd,
    output logic              ctrl_wr
);

    localparam int N_GRP = 3;
    localparam logic [ADDR_W-1:0] GRP_ADDR [N_GRP] = '{
        ADDR_W'(OFF_STAT_A), ADDR_W'(OFF_STAT_B), ADDR_W'(OFF_STAT_C)
    };

    logic [N_GRP-1:0] grp_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_GRP; gi++) begin : g_grp
            assign grp_hit[gi] = (addr == GRP_ADDR[gi]);
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (|grp_hit)                          sel = SEL_GRP;
        else if (addr == ADDR_W'(OFF_STAT_X))  sel = SEL_AUX;
        else if (addr == ADDR_W'(OFF_CTRL))    sel = SEL_CTRL;
    end

    assign grp_rd  = rd && (sel == SEL_GRP);
    assign ctrl_wr = wr && (sel == SEL_CTRL);

endmodule

// File: rtl/pos_csr_ctrl.sv
module pos_csr_ctrl
    import pos_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_val,
    output logic              crc_long,
    output logic              bad_val
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              crc_long;
        logic              bad;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (wr_en) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            if (wdata == DATA_W'(CTRL_WORD_LONG)) begin
                st_d.crc_long = 1'b1;
            end else if (wdata == DATA_W'(CTRL_WORD_SHORT)) begin
                st_d.crc_long = 1'b0;
            end else begin
                st_d.crc_long = 1'b0;
                st_d.bad      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_val = st_q.ctrl;
    assign crc_long = st_q.crc_long;
    assign bad_val  = st_q.bad;

endmodule

// File: rtl/pos_csr_irq.sv
module pos_csr_irq #(
    parameter int CLR_READS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic grp_rd,
    output logic irq
);

    localparam int CNT_W = $clog2(CLR_READS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLR_READS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       clear_hit;

    always_comb begin
        st_d      = st_q;
        clear_hit = 1'b0;
        if (grp_rd) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                clear_hit = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.irq = set_evt || (st_q.irq && !clear_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/pos_csr_bank.sv
module pos_csr_bank
    import pos_csr_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int CTRL_W     = 16,
    parameter int CLR_READS  = 20,
    parameter int GRP_VALUE  = 32'h0000_0FFF,
    parameter int AUX_VALUE  = 32'h0000_007F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_set,
    output logic              irq_out,
    output logic              crc_long,
    output logic              ctrl_bad
);

    csr_sel_e          sel;
    logic              grp_rd;
    logic              ctrl_wr;
    logic [CTRL_W-1:0] ctrl_val;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    pos_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .sel     (sel),
        .grp_rd  (grp_rd),
        .ctrl_wr (ctrl_wr)
    );

    pos_csr_ctrl #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wdata    (bus_wdata),
        .ctrl_val (ctrl_val),
        .crc_long (crc_long),
        .bad_val  (ctrl_bad)
    );

    pos_csr_irq #(.CLR_READS(CLR_READS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (irq_set),
        .grp_rd  (grp_rd),
        .irq     (irq_out)
    );

    always_comb begin
        rd_d.rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_GRP:  rd_d.rdata = DATA_W'(GRP_VALUE);
                SEL_AUX:  rd_d.rdata = DATA_W'(AUX_VALUE);
                SEL_CTRL: rd_d.rdata = DATA_W'(ctrl_val);
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

endmodule

// File: rtl/pos_csr_bank_chk.sv
module pos_csr_bank_chk
    import pos_csr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_set,
    input logic              irq_out,
    input logic              crc_long,
    input logic              ctrl_bad
);

    logic grp_addr;
    assign grp_addr = (bus_addr == ADDR_W'(OFF_STAT_A)) ||
                      (bus_addr == ADDR_W'(OFF_STAT_B)) ||
                      (bus_addr == ADDR_W'(OFF_STAT_C));

    assert_grp_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && grp_addr) |=> (bus_rdata == DATA_W'(32'h0000_0FFF)));

    assert_aux_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_STAT_X)) |=> (bus_rdata == DATA_W'(32'h0000_007F)));

    assert_long_crc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata == DATA_W'(CTRL_WORD_LONG))
        |=> (crc_long && !ctrl_bad));

    assert_bad_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bad |-> !crc_long);

    assert_set_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq_out);

    assert_fall_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(bus_rd && grp_addr && !irq_set));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind pos_csr_bank pos_csr_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_set   (irq_set),
    .irq_out   (irq_out),
    .crc_long  (crc_long),
    .ctrl_bad  (ctrl_bad)
);

// File: tb/pos_csr_bank_bench.sv
`timescale 1ns/1ps
module pos_csr_bank_bench;

    localparam logic [23:0] A_GA = 24'h300000;
    localparam logic [23:0] A_GB = 24'h300004;
    localparam logic [23:0] A_GC = 24'h30001C;
    localparam logic [23:0] A_AX = 24'h300008;
    localparam logic [23:0] A_CT = 24'h300028;
    localparam logic [23:0] A_NO = 24'h300030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_set = 1'b0;
    logic        irq_out;
    logic        crc_long;
    logic        ctrl_bad;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pos_csr_bank u_pos_csr_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_set   (irq_set),
        .irq_out   (irq_out),
        .crc_long  (crc_long),
        .ctrl_bad  (ctrl_bad)
    );

    // Behavioural reference model
    int unsigned m_rdata = 0;
    int unsigned m_ctrl  = 0;
    int          m_cnt   = 0;
    bit          m_irq   = 0;
    bit          m_crc   = 0;
    bit          m_bad   = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rdata = 0; m_ctrl = 0; m_cnt = 0; m_irq = 0; m_crc = 0; m_bad = 0;
        end else begin
            bit is_grp;
            bit clr;
            int unsigned nr;
            is_grp = (bus_addr == A_GA) || (bus_addr == A_GB) || (bus_addr == A_GC);
            nr = 0;
            if (bus_rd) begin
                if (is_grp)                 nr = 32'hFFF;
                else if (bus_addr == A_AX)  nr = 32'h7F;
                else if (bus_addr == A_CT)  nr = m_ctrl;
            end
            clr = 0;
            if (bus_rd && is_grp) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == 20) begin m_cnt = 0; clr = 1; end
            end
            m_irq = irq_set || (m_irq && !clr);
            m_bad = 0;
            if (bus_wr && bus_addr == A_CT) begin
                m_ctrl = bus_wdata & 32'hFFFF;
                if (bus_wdata == 32'h7)      m_crc = 1;
                else if (bus_wdata == 32'h6) m_crc = 0;
                else begin m_crc = 0; m_bad = 1; end
            end
            m_rdata = nr;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2 rdata model", bus_rdata, m_rdata);
            chk("R8 irq model", {31'd0, irq_out}, {31'd0, m_irq});
            chk("R5 crc model", {31'd0, crc_long}, {31'd0, m_crc});
            chk("R6 bad model", {31'd0, ctrl_bad}, {31'd0, m_bad});
        end
    end

    task automatic step(bit rd, bit wr, logic [23:0] a, logic [31:0] wd, bit s);
        @(negedge clk);
        #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; irq_set = s;
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 0);
    endtask

    task automatic rd_chk(string tag, logic [23:0] a, logic [31:0] exp);
        step(1, 0, a, '0, 0);
        idle();
        chk(tag, bus_rdata, exp);
    endtask

    task automatic grp_reads(int n);
        for (int i = 0; i < n; i++) step(1, 0, (i % 2 == 0) ? A_GB : A_GC, '0, 0);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 irq", {31'd0, irq_out}, 0);
        chk("R1 crc", {31'd0, crc_long}, 0);
        chk("R1 bad", {31'd0, ctrl_bad}, 0);
        rd_chk("R1 ctrl", A_CT, 0);

        rd_chk("R2 grp a", A_GA, 32'hFFF);
        rd_chk("R2 grp b", A_GB, 32'hFFF);
        rd_chk("R2 grp c", A_GC, 32'hFFF);
        rd_chk("R3 aux", A_AX, 32'h7F);
        idle();
        chk("R11 idle", bus_rdata, 0);

        step(0, 1, A_CT, 32'h7, 0); idle();
        chk("R5 long", {31'd0, crc_long}, 1);
        rd_chk("R4 readback", A_CT, 32'h7);
        step(0, 1, A_CT, 32'h6, 0); idle();
        chk("R5 short", {31'd0, crc_long}, 0);
        chk("R5 no bad", {31'd0, ctrl_bad}, 0);
        step(0, 1, A_CT, 32'h7, 0);
        step(0, 1, A_CT, 32'h0001_2345, 0); idle();
        chk("R6 bad pulse", {31'd0, ctrl_bad}, 1);
        chk("R6 crc short", {31'd0, crc_long}, 0);
        idle();
        chk("R6 pulse ends", {31'd0, ctrl_bad}, 0);
        rd_chk("R4 low half", A_CT, 32'h2345);
        step(0, 1, A_CT, 32'h0001_0007, 0); idle();
        chk("R6 wide word", {31'd0, crc_long}, 0);
        chk("R6 wide bad", {31'd0, ctrl_bad}, 1);

        step(0, 1, A_CT, 32'h7, 0);
        step(0, 1, A_NO, 32'h6, 0); idle();
        chk("R10 crc kept", {31'd0, crc_long}, 1);
        rd_chk("R10 ctrl kept", A_CT, 32'h7);
        rd_chk("R10 undecoded read", A_NO, 0);

        // Counter at 3 from the R2 reads; raise the interrupt
        step(0, 0, '0, '0, 1); idle();
        chk("R7 raise", {31'd0, irq_out}, 1);
        grp_reads(10);
        rd_chk("R8 aux not counted", A_AX, 32'h7F);
        rd_chk("R8 ctrl not counted", A_CT, 32'h7);
        step(0, 0, '0, '0, 1); idle();
        chk("R9 set while high", {31'd0, irq_out}, 1);
        grp_reads(6);
        chk("R8 high after 19", {31'd0, irq_out}, 1);
        step(1, 0, A_GA, '0, 0); idle();
        chk("R8 cleared on 20th", {31'd0, irq_out}, 0);

        step(0, 0, '0, '0, 1);
        grp_reads(19);
        chk("R12 high before", {31'd0, irq_out}, 1);
        step(1, 0, A_GA, '0, 1); idle();
        chk("R12 set wins", {31'd0, irq_out}, 1);
        grp_reads(19);
        chk("R12 count restarted", {31'd0, irq_out}, 1);
        step(1, 0, A_GC, '0, 0); idle();
        chk("R12 then clears", {31'd0, irq_out}, 0);

        repeat (3) idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule